// File: doc/BRIEF.md
# Status-Poll Completion Checker

This block sits on the host side of a flash interface. Once a program or erase command has been issued elsewhere, it decides whether that operation succeeded. A single start pulse hands it two values: the expected datum (the programmed byte, or all ones for an erase) and a poll address. The poll address must be the programmed location, an address inside a sector chosen for erasure, or, for a whole-chip erase, any unprotected sector. The block then reads the status byte at that address over a request/acknowledge read port, again and again, until it reaches a verdict.

Each status byte is judged on two bits. The completion bit (bit 7) is compared with bit 7 of the expected datum. The time-limit bit (bit 5) marks that the device has exceeded its internal limit. A set time-limit bit does not end the check on its own. The completion bit can flip in the same read that raises the time-limit bit, so the checker issues one more read and decides on the completion bit of that read.

The completion bit can settle before the other seven bits do. For this reason, after every pass verdict the checker issues one further read and presents that byte as the verified data. A configurable guard limit stops an endless poll loop with a fail verdict.

Top module: `dpoll_verifier`

## Requirements
- R1: After reset, rdReq, done, pass, fail and verData are all 0.
- R2: When start is sampled high while idle, the checker captures expData and pollAddr. rdReq is high from the next cycle, and rdAddr equals the captured address for every read of that check. A start pulse that arrives during a check is ignored.
- R3: A read is complete when rdReq and rdAck are both high in a cycle. If bit 7 of that byte equals bit 7 of the captured expected datum, the checker issues exactly one more read, loads that byte into verData and ends with pass.
- R4: If a poll byte has bit 7 different from the expected bit and bit 5 equal to 0, the checker issues another poll read.
- R5: If a poll byte has bit 7 different and bit 5 equal to 1, exactly one re-check read follows. If its bit 7 matches, the flow continues as in R3. If it does not match, the check ends with fail, no further read is issued, and verData keeps its previous value.
- R6: With an expected datum of 8'hFF (erase), a status byte with bit 7 = 1 counts as a match, and one with bit 7 = 0 counts as in progress.
- R7: done is high for exactly one cycle, in the cycle after the deciding read completes. pass and fail are never high together. Exactly one of them is high with done, and it stays high until the next accepted start, which clears both.
- R8: If MAX_POLLS poll reads in a row all show bit 7 different and bit 5 = 0, the check ends with fail after the last of them. A set bit 5 on the final allowed poll still earns its re-check read.
- R9: rdAck while rdReq is low has no effect. While a request waits for its acknowledge, rdReq stays high and rdAddr holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a check (accepted only when idle) |
| expData | input | DATA_W | Expected datum (programmed byte, or all ones for erase) |
| pollAddr | input | ADDR_W | Address to poll |
| rdReq | output | 1 | Read request, held until acknowledged |
| rdAddr | output | ADDR_W | Read address |
| rdAck | input | 1 | Read acknowledge; rdData valid in the same cycle |
| rdData | input | DATA_W | Status or data byte returned by the read |
| done | output | 1 | One-cycle pulse when a verdict is reached |
| pass | output | 1 | Verdict: operation succeeded (held) |
| fail | output | 1 | Verdict: operation failed (held) |
| verData | output | DATA_W | Byte from the read that follows a pass |

## Verification
The bench targets the time-limit path. A checker that treats a set bit 5 as final would report fail on a byte sequence whose re-check read matches. A checker that skips the re-check would read one byte too few. Both show up as a wrong verdict or a wrong read count. It also runs checks that end exactly on the guard boundary, one poll before the limit and on the limit itself, with and without bit 5. An off-by-one counter passes or fails a poll early. The extra read after a match is checked with distinct byte values, so a design that reports the matching status byte as the verified data is caught. Stray acknowledges while idle and a second start during a check are also tried; either one would corrupt the verdict or the address.

// File: rtl/dpoll_pkg.sv
package dpoll_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_POLL,
    ST_RECHECK,
    ST_VERIFY
  } pollState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCmd;
    logic countPoll;
    logic captureVer;
    logic setPass;
    logic setFail;
  } pollCtrl_t;

  // conditions from datapath to control
  typedef struct packed {
    logic bitMatch;
    logic toutSet;
    logic guardHit;
  } pollFlags_t;

endpackage

// File: rtl/dpoll_datapath.sv
module dpoll_datapath
  import dpoll_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 18,
  parameter int MAX_POLLS = 4096,
  parameter bit GUARD_EN  = 1'b1,
  parameter int DONE_BIT  = 7,
  parameter int TOUT_BIT  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  pollCtrl_t         ctrl,
  input  logic [DATA_W-1:0] expData,
  input  logic [ADDR_W-1:0] pollAddr,
  input  logic [DATA_W-1:0] rdData,
  output pollFlags_t        flags,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] verData,
  output logic              done,
  output logic              pass,
  output logic              fail
);

  localparam int CNT_W = $clog2(MAX_POLLS + 1);

  logic [DATA_W-1:0] expReg;
  logic [ADDR_W-1:0] addrReg;

  // command capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      expReg  <= '0;
      addrReg <= '0;
    end else if (ctrl.loadCmd) begin
      expReg  <= expData;
      addrReg <= pollAddr;
    end
  end

  assign rdAddr = addrReg;

  // verdict registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pass <= 1'b0;
      fail <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= ctrl.setPass | ctrl.setFail;
      if (ctrl.loadCmd) begin
        pass <= 1'b0;
        fail <= 1'b0;
      end else begin
        if (ctrl.setPass) pass <= 1'b1;
        if (ctrl.setFail) fail <= 1'b1;
      end
    end
  end

  // verified data capture
  always_ff @(posedge clk) begin
    if (!rstN) verData <= '0;
    else if (ctrl.captureVer) verData <= rdData;
  end

  // status decode
  always_comb begin
    flags.bitMatch = (rdData[DONE_BIT] == expReg[DONE_BIT]);
    flags.toutSet  = rdData[TOUT_BIT];
  end

  // optional guard counter
  generate
    if (GUARD_EN) begin : g_guard
      logic [CNT_W-1:0] pollCnt;
      always_ff @(posedge clk) begin
        if (!rstN) pollCnt <= '0;
        else if (ctrl.loadCmd) pollCnt <= '0;
        else if (ctrl.countPoll) pollCnt <= pollCnt + 1'b1;
      end
      assign flags.guardHit = (pollCnt == CNT_W'(MAX_POLLS - 1));
    end else begin : g_noGuard
      assign flags.guardHit = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/dpoll_control.sv
module dpoll_control
  import dpoll_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       rdAck,
  input  pollFlags_t flags,
  output pollCtrl_t  ctrl,
  output logic       rdReq
);

  pollState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else state <= nextState;
  end

  assign rdReq = (state != ST_IDLE);

  always_comb begin
    ctrl      = '0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (start) begin
          ctrl.loadCmd = 1'b1;
          nextState    = ST_POLL;
        end
      end
      ST_POLL: begin
        if (rdAck) begin
          if (flags.bitMatch) begin
            nextState = ST_VERIFY;
          end else if (flags.toutSet) begin
            nextState = ST_RECHECK;
          end else if (flags.guardHit) begin
            ctrl.setFail = 1'b1;
            nextState    = ST_IDLE;
          end else begin
            ctrl.countPoll = 1'b1;
          end
        end
      end
      ST_RECHECK: begin
        if (rdAck) begin
          if (flags.bitMatch) begin
            nextState = ST_VERIFY;
          end else begin
            ctrl.setFail = 1'b1;
            nextState    = ST_IDLE;
          end
        end
      end
      ST_VERIFY: begin
        if (rdAck) begin
          ctrl.captureVer = 1'b1;
          ctrl.setPass    = 1'b1;
          nextState       = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/dpoll_verifier.sv
module dpoll_verifier
  import dpoll_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 18,
  parameter int MAX_POLLS = 4096,
  parameter bit GUARD_EN  = 1'b1,
  parameter int DONE_BIT  = 7,
  parameter int TOUT_BIT  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [DATA_W-1:0] expData,
  input  logic [ADDR_W-1:0] pollAddr,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic              rdAck,
  input  logic [DATA_W-1:0] rdData,
  output logic              done,
  output logic              pass,
  output logic              fail,
  output logic [DATA_W-1:0] verData
);

  pollCtrl_t  ctrl;
  pollFlags_t flags;

  dpoll_control u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .rdAck (rdAck),
    .flags (flags),
    .ctrl  (ctrl),
    .rdReq (rdReq)
  );

  dpoll_datapath #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .MAX_POLLS (MAX_POLLS),
    .GUARD_EN  (GUARD_EN),
    .DONE_BIT  (DONE_BIT),
    .TOUT_BIT  (TOUT_BIT)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .expData  (expData),
    .pollAddr (pollAddr),
    .rdData   (rdData),
    .flags    (flags),
    .rdAddr   (rdAddr),
    .verData  (verData),
    .done     (done),
    .pass     (pass),
    .fail     (fail)
  );

endmodule

// File: rtl/dpoll_verifier_chk.sv
module dpoll_verifier_chk #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              rdReq,
  input logic              rdAck,
  input logic [ADDR_W-1:0] rdAddr,
  input logic              done,
  input logic              pass,
  input logic              fail
);

  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(pass && fail));

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r7_done_verdict: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (pass ^ fail));

  a_r7_pass_held: assert property (@(posedge clk) disable iff (!rstN)
    (pass && !start) |=> pass);

  a_r7_fail_held: assert property (@(posedge clk) disable iff (!rstN)
    (fail && !start) |=> fail);

  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !rdAck) |=> rdReq);

  a_r9_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !rdAck) |=> $stable(rdAddr));

  a_r5_no_read_after_verdict: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !rdReq);

endmodule

bind dpoll_verifier dpoll_verifier_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .start  (start),
  .rdReq  (rdReq),
  .rdAck  (rdAck),
  .rdAddr (rdAddr),
  .done   (done),
  .pass   (pass),
  .fail   (fail)
);

// File: tb/tb_dpoll_verifier.sv
module tb_dpoll_verifier;
  localparam int DW = 8;
  localparam int AW = 18;
  localparam int MAXP = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic rdAck = 1'b0;
  logic [DW-1:0] expData = '0;
  logic [DW-1:0] rdData = '0;
  logic [AW-1:0] pollAddr = '0;
  logic rdReq, done, pass, fail;
  logic [AW-1:0] rdAddr;
  logic [DW-1:0] verData;

  always #2 clk = ~clk;

  dpoll_verifier #(.DATA_W(DW), .ADDR_W(AW), .MAX_POLLS(MAXP)) dut (
    .clk(clk), .rstN(rstN), .start(start), .expData(expData),
    .pollAddr(pollAddr), .rdReq(rdReq), .rdAddr(rdAddr), .rdAck(rdAck),
    .rdData(rdData), .done(done), .pass(pass), .fail(fail), .verData(verData)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [7:0] script [64];
  int scriptLen = 1;
  int readsDone = 0;
  int addrErrs = 0;
  int ackOdds = 1;
  bit strayReq = 0;
  logic [AW-1:0] curAddr = '0;
  logic [7:0] lastVer = '0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // flash responder model
  always @(negedge clk) begin
    if (rdAck) begin
      rdAck = 1'b0;
    end else if (rdReq && ($urandom_range(0, ackOdds) == 0)) begin
      rdData = script[(readsDone < scriptLen) ? readsDone : scriptLen - 1];
      if (rdAddr !== curAddr) addrErrs++;
      readsDone++;
      rdAck = 1'b1;
    end else if (strayReq) begin
      rdData = 8'h80;
      rdAck = 1'b1;
      strayReq = 0;
    end
  end

  function automatic logic [7:0] at(input int i);
    return script[(i < scriptLen) ? i : scriptLen - 1];
  endfunction

  function automatic void predict(input logic [7:0] e, output bit ePass,
                                  output int eReads, output logic [7:0] eVer);
    int i = 0;
    int polls = 0;
    logic [7:0] b;
    ePass = 0;
    eVer = lastVer;
    while (1) begin
      b = at(i); i++;
      if (b[7] == e[7]) begin eVer = at(i); i++; ePass = 1; break; end
      if (b[5]) begin
        b = at(i); i++;
        if (b[7] == e[7]) begin eVer = at(i); i++; ePass = 1; end
        break;
      end
      polls++;
      if (polls == MAXP) break;
    end
    eReads = i;
  endfunction

  function automatic logic [7:0] misByte(input logic [7:0] e, input bit t5);
    logic [7:0] b = 8'($urandom);
    b[7] = ~e[7];
    b[5] = t5;
    return b;
  endfunction

  function automatic logic [7:0] hitByte(input logic [7:0] e);
    logic [7:0] b = 8'($urandom);
    b[7] = e[7];
    return b;
  endfunction

  // kind 0: match, 1: bit5 then match, 2: bit5 then mismatch, 3: never decides
  task automatic build(input logic [7:0] e, input int kind, input int nMis);
    int n = 0;
    for (int k = 0; k < nMis; k++) begin script[n] = misByte(e, 1'b0); n++; end
    case (kind)
      0: begin script[n] = hitByte(e); n++; end
      1: begin script[n] = misByte(e, 1'b1); n++; script[n] = hitByte(e); n++; end
      2: begin script[n] = misByte(e, 1'b1); n++; script[n] = misByte(e, 1'($urandom)); n++; end
      default: begin script[n] = misByte(e, 1'b0); n++; end
    endcase
    script[n] = ~script[n-1];  // verify byte differs from status byte
    n++;
    scriptLen = (kind == 3) ? 1 : n;
  endtask

  task automatic runCheck(input logic [7:0] e, input logic [AW-1:0] addr,
                          input string req, input bit restart);
    bit ePass;
    int eReads;
    logic [7:0] eVer;
    int n = 0;
    predict(e, ePass, eReads, eVer);
    readsDone = 0;
    addrErrs = 0;
    curAddr = addr;
    @(negedge clk);
    expData = e; pollAddr = addr; start = 1'b1;
    @(negedge clk);
    start = 1'b0; expData = ~e; pollAddr = ~addr;
    check("R2 rdReq after start", rdReq, 1);
    check("R7 verdict cleared by start", {pass, fail}, 0);
    if (restart) begin
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (done !== 1'b1) begin
      @(negedge clk);
      n++;
      if (n > 4000) break;
    end
    check({req, " pass"}, pass, ePass);
    check({req, " fail"}, fail, !ePass);
    check({req, " read count"}, readsDone, eReads);
    check({req, " verData"}, verData, eVer);
    check("R2 address per read", addrErrs, 0);
    lastVer = eVer;
    @(negedge clk);
    check("R7 done one cycle", done, 0);
    check("R5 no read after verdict", rdReq, 0);
    check("R7 verdict held", {pass, fail}, {ePass, !ePass});
  endtask

  initial begin
    #(4 * 190000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 rdReq", rdReq, 0);
    check("R1 done", done, 0);
    check("R1 pass/fail", {pass, fail}, 0);
    check("R1 verData", verData, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R9 stray acknowledge while idle
    strayReq = 1;
    repeat (4) @(negedge clk);
    check("R9 stray ack no done", done, 0);
    check("R9 stray ack no verdict", {pass, fail, rdReq}, 0);

    // R3 immediate match, program
    build(8'h5A, 0, 0);
    runCheck(8'h5A, 18'h00123, "R3 immediate match", 0);
    // R4 several in-progress polls then match
    build(8'hC3, 0, 4);
    runCheck(8'hC3, 18'h3ABCD, "R4 polls then match", 0);
    // R6 erase expected all ones
    build(8'hFF, 0, 3);
    runCheck(8'hFF, 18'h20000, "R6 erase match", 0);
    build(8'hFF, 2, 2);
    runCheck(8'hFF, 18'h20001, "R6 erase timeout fail", 0);
    // R5 timeout then match / mismatch
    build(8'h11, 1, 2);
    runCheck(8'h11, 18'h00F00, "R5 timeout recheck pass", 0);
    build(8'h91, 2, 1);
    runCheck(8'h91, 18'h00F01, "R5 timeout recheck fail", 0);
    // R8 guard boundaries
    build(8'h80, 0, MAXP - 1);
    runCheck(8'h80, 18'h11111, "R8 match on last poll", 0);
    build(8'h80, 3, 0);
    runCheck(8'h80, 18'h22222, "R8 guard fail", 0);
    build(8'h00, 1, MAXP - 1);
    runCheck(8'h00, 18'h33333, "R8 bit5 on last poll", 0);
    // R2 second start during a check ignored
    ackOdds = 3;
    build(8'h42, 0, 5);
    runCheck(8'h42, 18'h0ACE1, "R2 restart ignored", 1);

    // random mix
    for (int t = 0; t < 40; t++) begin
      logic [7:0] e;
      int kind;
      ackOdds = $urandom_range(0, 3);
      e = ($urandom_range(0, 3) == 0) ? 8'hFF : 8'($urandom);
      kind = $urandom_range(0, 3);
      build(e, kind, $urandom_range(0, MAXP - 1));
      runCheck(e, AW'($urandom), "R3 R4 R5 R8 random", 0);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule